// File: doc/BRIEF.md
# Closed-Loop Undervolting Voltage Controller

This block searches downward for the lowest supply setting at which a circuit still runs cleanly, then parks a programmable margin above the point where errors first appeared and keeps watching. It drives an unsigned voltage code toward an external regulator. It receives one-cycle error pulses from detectors such as timing-error flags or corrected-ECC events.

After a start request, the controller begins at the upper code limit and alternates between three kinds of interval. A settle interval blanks error counting while the regulator moves. An observation window counts errors. A step then lowers the code. When the error count in a window goes past the programmable threshold, the controller returns at once to the last clean code. It then moves to the first-failure code plus the guard amount and enters a hold phase. In the hold phase the same window keeps counting. A later rise in errors, from heating or wear for example, raises the code by one step.

The state and the last clean code are visible on status outputs, so surrounding logic can follow the search.

Top module: `uv_volt_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `vcode_o` and `last_good_o` equal `VCODE_RST` (default 255) and `state_o` is IDLE. The state codes are IDLE=0, STEP_DOWN=1, SETTLE=2, OBSERVE=3, BACKOFF=4 and HOLD=5.
- R2: In IDLE, a high `start_i` loads `cfg_vmax_i` into both `vcode_o` and `last_good_o` and moves to SETTLE. In any other state `start_i` has no effect.
- R3: Each STEP_DOWN lowers the code by `cfg_step_i` and never goes below `cfg_vmin_i`. From start onward the code stays within [vmin, vmax], given vmin <= vmax.
- R4: SETTLE lasts `cfg_settle_i`+1 cycles, and error pulses during it are not counted.
- R5: An observation window is `cfg_win_len_i` cycles long (0 acts as 1) and restarts on each entry to OBSERVE or HOLD. A violation occurs when a pulse would raise the count in the current window above `cfg_thresh_i`. If no window ever holds more than the threshold, the code does not change.
- R6: The pulse in the last cycle of a window is counted in the next window.
- R7: A violation in OBSERVE puts the controller in BACKOFF on the next cycle, with `vcode_o` equal to the last clean code. The violating code is recorded as the first-failure code.
- R8: BACKOFF lasts one cycle. It then sets the code and `last_good_o` to the larger of the last clean code and min(first-failure + `cfg_guard_i`, vmax), passes through SETTLE, and enters HOLD.
- R9: If a window at vmin ends cleanly, the code becomes min(vmin + guard, vmax) and the controller enters HOLD after a settle interval.
- R10: A violation in HOLD raises the code by one step, clamped to vmax, loads it into `last_good_o`, and returns to HOLD after a settle interval.
- R11: Every window that ends without a violation, in OBSERVE or HOLD, loads the current code into `last_good_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin the search (acted on only in IDLE) |
| err_pulse_i | input | 1 | One error event in this cycle |
| cfg_vmax_i | input | CODE_W | Upper code limit and search starting point |
| cfg_vmin_i | input | CODE_W | Lower code limit |
| cfg_step_i | input | CODE_W | Code change per step (at least 1) |
| cfg_guard_i | input | CODE_W | Margin added above the first-failure code |
| cfg_thresh_i | input | ERR_W | Highest tolerated error count per window |
| cfg_win_len_i | input | CNT_W | Window length in cycles |
| cfg_settle_i | input | CNT_W | Settle blanking length minus one |
| vcode_o | output | CODE_W | Voltage code to the regulator |
| state_o | output | 3 | Current controller state |
| last_good_o | output | CODE_W | Last code that passed a window cleanly |

## Verification
The hardest situation to reach from the ports is a pulse that lands exactly on a window's last cycle during HOLD. Window phase is hidden, so the bench sees it only through `state_o`. It takes the cycle in which HOLD first appears as window cycle zero and counts from there. It places one pulse just before the boundary and one on it, checks that nothing moves, and then sends a third pulse that must push the code up. The random searches draw a hidden failure code and send errors whenever the code is at or below it. They also send noise during every settle interval, which tests blanking, and they compare the back-off value and the guarded hold point with values the bench computes from the code sequence.

// File: rtl/uv_pkg.sv
`timescale 1ns/100ps
// Shared definitions for the undervolting controller.
// Assumes: state codes are visible on a 3-bit status port and must stay fixed.
package uv_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_STEP_DN = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_OBSERVE = 3'd3,
        ST_BACKOFF = 3'd4,
        ST_HOLD    = 3'd5
    } uv_state_e;
endpackage

// File: rtl/uv_code_math.sv
`timescale 1ns/100ps
// Combinational code arithmetic: step down, step up, floor hold point and
// back-off hold point, each clamped to the configured [vmin, vmax] range.
// Assumes: vmin <= vmax; sums are formed one bit wider to catch overflow.
module uv_code_math #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] cur_i,
    input  logic [CODE_W-1:0] last_good_i,
    input  logic [CODE_W-1:0] fail_i,
    input  logic [CODE_W-1:0] step_i,
    input  logic [CODE_W-1:0] guard_i,
    input  logic [CODE_W-1:0] vmin_i,
    input  logic [CODE_W-1:0] vmax_i,
    output logic [CODE_W-1:0] down_o,
    output logic [CODE_W-1:0] up_o,
    output logic [CODE_W-1:0] floor_hold_o,
    output logic [CODE_W-1:0] backoff_hold_o
);
    localparam int EXT_W = CODE_W + 1;

    logic [EXT_W-1:0] min_plus_step;
    logic [EXT_W-1:0] cur_plus_step;
    logic [EXT_W-1:0] fail_plus_guard;
    logic [EXT_W-1:0] min_plus_guard;
    logic [CODE_W-1:0] guarded_fail;

    // Wide sums used by every clamp below.
    always_comb begin
        min_plus_step   = {1'b0, vmin_i} + {1'b0, step_i};
        cur_plus_step   = {1'b0, cur_i} + {1'b0, step_i};
        fail_plus_guard = {1'b0, fail_i} + {1'b0, guard_i};
        min_plus_guard  = {1'b0, vmin_i} + {1'b0, guard_i};
    end

    // One step lower, never beneath vmin.
    always_comb begin
        if ({1'b0, cur_i} < min_plus_step) down_o = vmin_i;
        else                               down_o = cur_i - step_i;
    end

    // One step higher, never above vmax.
    always_comb begin
        if (cur_plus_step > {1'b0, vmax_i}) up_o = vmax_i;
        else                                up_o = cur_plus_step[CODE_W-1:0];
    end

    // Hold point when the floor is reached without failures.
    always_comb begin
        if (min_plus_guard > {1'b0, vmax_i}) floor_hold_o = vmax_i;
        else                                 floor_hold_o = min_plus_guard[CODE_W-1:0];
    end

    // Hold point after a search failure: guarded failure code, at least last good.
    always_comb begin
        if (fail_plus_guard > {1'b0, vmax_i}) guarded_fail = vmax_i;
        else                                  guarded_fail = fail_plus_guard[CODE_W-1:0];
        backoff_hold_o = (last_good_i > guarded_fail) ? last_good_i : guarded_fail;
    end
endmodule

// File: rtl/uv_settle_timer.sv
`timescale 1ns/100ps
// Blanking timer run while the regulator output moves to a new code.
// Held at zero while inactive; done is raised on the (len+1)-th active cycle.
// Assumes: active drops in the cycle after done.
module uv_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);
    logic [CNT_W-1:0] elapsed;

    // Count active cycles; clear whenever the timer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) elapsed <= '0;
        else if (!done_o)        elapsed <= elapsed + 1'b1;
    end

    assign done_o = active_i && (elapsed == len_i);

    assert_elapsed_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (elapsed <= len_i));
endmodule

// File: rtl/uv_err_window.sv
`timescale 1ns/100ps
// Sliding error window: a cycle counter of programmable length and a
// saturating error count cleared at every window boundary. A pulse on the
// boundary cycle starts the next window's count. "over" flags a pulse that
// would take the window count above the threshold.
// Assumes: both counters are cleared whenever counting is inactive.
module uv_err_window #(
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             err_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic [ERR_W-1:0] thresh_i,
    output logic             boundary_o,
    output logic             over_o
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    logic [CNT_W-1:0] cyc;
    logic [ERR_W-1:0] errs;
    logic [CNT_W-1:0] last_idx;
    logic [ERR_W-1:0] base;

    // Last cycle index of a window; zero length behaves as one.
    always_comb begin
        last_idx   = (len_i == '0) ? '0 : len_i - 1'b1;
        boundary_o = active_i && (cyc == last_idx);
        base       = boundary_o ? '0 : errs;
        over_o     = active_i && err_i && (base == thresh_i);
    end

    // Advance the window position and error count.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            cyc  <= '0;
            errs <= '0;
        end else begin
            cyc <= boundary_o ? '0 : cyc + 1'b1;
            if (boundary_o)                 errs <= {{(ERR_W-1){1'b0}}, err_i};
            else if (err_i && errs != ERR_MAX) errs <= errs + 1'b1;
        end
    end

    assert_fresh_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |=> (!active_i || errs <= 1));

    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !over_o) |=> (!active_i || errs <= thresh_i));
endmodule

// File: rtl/uv_volt_ctrl.sv
`timescale 1ns/100ps
// Closed-loop undervolting controller (top). Steps the voltage code down from
// vmax, blanks errors during settle, watches a sliding error window, restores
// the last clean code on a violation, then holds at the guarded failure point
// and raises the code if errors return.
// Assumes: configuration is stable from start onward, vmin <= vmax, step >= 1.
module uv_volt_ctrl #(
    parameter int                CODE_W    = 8,
    parameter int                CNT_W     = 16,
    parameter int                ERR_W     = 8,
    parameter logic [CODE_W-1:0] VCODE_RST = {CODE_W{1'b1}}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      err_pulse_i,
    input  logic [CODE_W-1:0]         cfg_vmax_i,
    input  logic [CODE_W-1:0]         cfg_vmin_i,
    input  logic [CODE_W-1:0]         cfg_step_i,
    input  logic [CODE_W-1:0]         cfg_guard_i,
    input  logic [ERR_W-1:0]          cfg_thresh_i,
    input  logic [CNT_W-1:0]          cfg_win_len_i,
    input  logic [CNT_W-1:0]          cfg_settle_i,
    output logic [CODE_W-1:0]         vcode_o,
    output logic [uv_pkg::STATE_W-1:0] state_o,
    output logic [CODE_W-1:0]         last_good_o
);
    import uv_pkg::*;

    uv_state_e         state;
    logic [CODE_W-1:0] vcode;
    logic [CODE_W-1:0] last_good;
    logic [CODE_W-1:0] fail_code;
    logic              searching;

    logic              win_active;
    logic              settle_active;
    logic              settle_done;
    logic              win_boundary;
    logic              win_over;
    logic [CODE_W-1:0] down_code;
    logic [CODE_W-1:0] up_code;
    logic [CODE_W-1:0] floor_hold;
    logic [CODE_W-1:0] backoff_hold;

    // Decode which timers run in the current state.
    always_comb begin
        win_active    = (state == ST_OBSERVE) || (state == ST_HOLD);
        settle_active = (state == ST_SETTLE);
    end

    uv_settle_timer #(.CNT_W(CNT_W)) i_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (settle_active),
        .len_i    (cfg_settle_i),
        .done_o   (settle_done)
    );

    uv_err_window #(.CNT_W(CNT_W), .ERR_W(ERR_W)) i_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (win_active),
        .err_i      (err_pulse_i),
        .len_i      (cfg_win_len_i),
        .thresh_i   (cfg_thresh_i),
        .boundary_o (win_boundary),
        .over_o     (win_over)
    );

    uv_code_math #(.CODE_W(CODE_W)) i_math (
        .cur_i          (vcode),
        .last_good_i    (last_good),
        .fail_i         (fail_code),
        .step_i         (cfg_step_i),
        .guard_i        (cfg_guard_i),
        .vmin_i         (cfg_vmin_i),
        .vmax_i         (cfg_vmax_i),
        .down_o         (down_code),
        .up_o           (up_code),
        .floor_hold_o   (floor_hold),
        .backoff_hold_o (backoff_hold)
    );

    // Search / hold sequencer and code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            vcode     <= VCODE_RST;
            last_good <= VCODE_RST;
            fail_code <= VCODE_RST;
            searching <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        vcode     <= cfg_vmax_i;
                        last_good <= cfg_vmax_i;
                        searching <= 1'b1;
                        state     <= ST_SETTLE;
                    end
                end
                ST_STEP_DN: begin
                    vcode <= down_code;
                    state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (settle_done) state <= searching ? ST_OBSERVE : ST_HOLD;
                end
                ST_OBSERVE: begin
                    if (win_over) begin
                        fail_code <= vcode;
                        vcode     <= last_good;
                        state     <= ST_BACKOFF;
                    end else if (win_boundary) begin
                        last_good <= vcode;
                        if (vcode <= cfg_vmin_i) begin
                            vcode     <= floor_hold;
                            searching <= 1'b0;
                            state     <= ST_SETTLE;
                        end else begin
                            state <= ST_STEP_DN;
                        end
                    end
                end
                ST_BACKOFF: begin
                    vcode     <= backoff_hold;
                    last_good <= backoff_hold;
                    searching <= 1'b0;
                    state     <= ST_SETTLE;
                end
                ST_HOLD: begin
                    if (win_over) begin
                        vcode     <= up_code;
                        last_good <= up_code;
                        state     <= ST_SETTLE;
                    end else if (win_boundary) begin
                        last_good <= vcode;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign vcode_o     = vcode;
    assign state_o     = state;
    assign last_good_o = last_good;

    assert_code_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cfg_vmin_i <= cfg_vmax_i) |->
            (vcode >= cfg_vmin_i && vcode <= cfg_vmax_i));

    assert_step_never_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP_DN) |=> (vcode <= $past(vcode)));

    assert_settle_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=>
            (state == ST_SETTLE || state == ST_OBSERVE || state == ST_HOLD));

    assert_restore_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OBSERVE && win_over) |=>
            (state == ST_BACKOFF && vcode == $past(last_good)));

    assert_backoff_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BACKOFF) |=> (state == ST_SETTLE));

    assert_hold_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && win_over) |=>
            (state == ST_SETTLE && vcode >= $past(vcode)));

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && start_i && !win_over) |=> (state == ST_HOLD));
endmodule

// File: tb/test_uv_volt_ctrl.sv
`timescale 1ns/100ps
module test_uv_volt_ctrl;
    localparam int S_IDLE = 0, S_STEP = 1, S_SETTLE = 2, S_OBS = 3, S_BACK = 4, S_HOLD = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        err = 1'b0;
    logic [7:0]  vmax = 8'd200, vmin = 8'd50, step = 8'd5, guard = 8'd10;
    logic [7:0]  thresh = 8'd0;
    logic [15:0] win_len = 16'd8, settle = 16'd2;
    logic [7:0]  vcode, last_good;
    logic [2:0]  state;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    uv_volt_ctrl i_uv_volt_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .err_pulse_i(err),
        .cfg_vmax_i(vmax), .cfg_vmin_i(vmin), .cfg_step_i(step), .cfg_guard_i(guard),
        .cfg_thresh_i(thresh), .cfg_win_len_i(win_len), .cfg_settle_i(settle),
        .vcode_o(vcode), .state_o(state), .last_good_o(last_good)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, sample just after the rising edge.
    task automatic cyc(input logic e, input logic s);
        @(negedge clk);
        err = e;
        start = s;
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_down(input int c);
        return (c < int'(vmin) + int'(step)) ? int'(vmin) : c - int'(step);
    endfunction

    function automatic int imin(input int a, input int b); return (a < b) ? a : b; endfunction
    function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction

    // Expected search outcome for a hidden failure code ft.
    task automatic predict(input int ft, output bit found, output int prev, output int hold, output int lg);
        int c = int'(vmax);
        prev = int'(vmax);
        found = 0;
        forever begin
            if (c <= ft) begin
                found = 1;
                hold = imax(prev, imin(c + int'(guard), int'(vmax)));
                lg = hold;
                break;
            end
            if (c == int'(vmin)) begin
                hold = imin(int'(vmin) + int'(guard), int'(vmax));
                lg = int'(vmin);
                break;
            end
            prev = c;
            c = exp_down(c);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        err = 1'b0;
        start = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run the search until HOLD is first seen; afterwards the current cycle is window cycle 0.
    task automatic run_search(input int ft, output bit saw_bo, output int bo_val, output int post_bo,
                              output int step_err, output int range_err, output int settle_err);
        int pstate, pv, run, guard_cnt;
        saw_bo = 0; bo_val = -1; post_bo = -1; step_err = 0; range_err = 0; settle_err = 0;
        cyc(1'b0, 1'b1);
        pstate = state; pv = vcode; run = (state == S_SETTLE) ? 1 : 0;
        guard_cnt = 0;
        while (state != S_HOLD && guard_cnt < 20000) begin
            logic e;
            e = (int'(vcode) <= ft) || (state == S_SETTLE && $urandom_range(0, 1) == 1);
            cyc(e, 1'b0);
            guard_cnt++;
            if (pstate == S_STEP && int'(vcode) != exp_down(pv)) step_err++;
            if (vcode < vmin || vcode > vmax) range_err++;
            if (pstate == S_BACK) post_bo = vcode;
            if (state == S_BACK && !saw_bo) begin saw_bo = 1; bo_val = vcode; end
            if (state == S_SETTLE) run++;
            else if (pstate == S_SETTLE) begin
                if (run != int'(settle) + 1) settle_err++;
                run = 0;
            end
            pstate = state; pv = vcode;
        end
    endtask

    task automatic scenario(input int ft, input bit extra);
        bit found, saw_bo;
        int prev, hold, lg, bo_val, post_bo, se, re, te, raised, base_code, sent, lim;
        do_reset();
        predict(ft, found, prev, hold, lg);
        run_search(ft, saw_bo, bo_val, post_bo, se, re, te);
        chk(state == S_HOLD, "R8/R9", "state at hold entry", state, S_HOLD);
        chk(int'(vcode) == hold, found ? "R8" : "R9", "hold code", vcode, hold);
        chk(int'(last_good) == lg, "R11", "last good at hold entry", last_good, lg);
        chk(se == 0 && re == 0, "R3", "step/range mismatches", se + re, 0);
        chk(te == 0, "R4", "settle length mismatches", te, 0);
        if (found) begin
            chk(saw_bo && bo_val == prev, "R7", "restored code in BACKOFF", bo_val, prev);
            chk(post_bo == hold, "R8", "code after BACKOFF", post_bo, hold);
        end else begin
            chk(!saw_bo, "R9", "BACKOFF seen on clean floor", saw_bo, 0);
        end
        if (!extra) return;
        // R10: burst of thresh+1 pulses from window cycle 0.
        for (int i = 0; i <= int'(thresh); i++) cyc(1'b1, 1'b0);
        raised = imin(hold + int'(step), int'(vmax));
        chk(int'(vcode) == raised && state == S_SETTLE, "R10", "code after hold violation", vcode, raised);
        chk(int'(last_good) == raised, "R10", "last good after raise", last_good, raised);
        lim = 0;
        while (state != S_HOLD && lim < 100) begin cyc(1'b0, 1'b0); lim++; end
        chk(state == S_HOLD, "R10", "return to HOLD", state, S_HOLD);
        // R5: at most thresh pulses in total never violate.
        base_code = vcode; sent = 0;
        for (int k = 0; k < 3 * int'(win_len); k++) begin
            logic e;
            e = (sent < int'(thresh)) && ($urandom_range(0, 1) == 1);
            if (e) sent++;
            cyc(e, 1'b0);
        end
        chk(int'(vcode) == base_code && state == S_HOLD, "R5", "code under threshold", vcode, base_code);
        // R2: start outside IDLE does nothing.
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        chk(int'(vcode) == base_code && state == S_HOLD, "R2", "start in HOLD", vcode, base_code);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        chk(vcode == 8'hFF, "R1", "vcode in reset", vcode, 255);
        chk(last_good == 8'hFF, "R1", "last good in reset", last_good, 255);
        chk(state == S_IDLE, "R1", "state in reset", state, S_IDLE);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);
        chk(state == S_IDLE && vcode == 8'hFF, "R1", "idle without start", vcode, 255);
        cyc(1'b0, 1'b1);
        chk(vcode == vmax && state == S_SETTLE, "R2", "start loads vmax", vcode, vmax);

        // R6: directed window boundary case.
        vmax = 8'd100; vmin = 8'd60; step = 8'd10; guard = 8'd10;
        thresh = 8'd1; win_len = 16'd6; settle = 16'd2;
        scenario(-1, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b0);
        chk(vcode == 8'd70 && state == S_HOLD, "R6", "boundary pulse in new window", vcode, 70);
        cyc(1'b1, 1'b0);
        chk(vcode == 8'd80, "R6", "second pulse of new window", vcode, 80);

        // Directed: failure at the very first code, guard clamped to vmax.
        vmax = 8'd100; vmin = 8'd40; step = 8'd7; guard = 8'd30;
        thresh = 8'd0; win_len = 16'd5; settle = 16'd1;
        scenario(100, 1'b1);
        // Directed: floor hold clamped to vmax, zero settle.
        vmax = 8'd100; vmin = 8'd95; step = 8'd3; guard = 8'd20;
        thresh = 8'd2; win_len = 16'd6; settle = 16'd0;
        scenario(10, 1'b1);

        // Constrained random scenarios.
        for (int n = 0; n < 20; n++) begin
            int l;
            vmax  = 8'(120 + $urandom_range(0, 130));
            vmin  = 8'(20 + $urandom_range(0, int'(vmax) - 51));
            step  = 8'(3 + $urandom_range(0, 9));
            guard = 8'($urandom_range(0, 24));
            l = 4 + $urandom_range(0, 16);
            win_len = 16'(l);
            thresh = 8'($urandom_range(0, imin(3, l - 2)));
            settle = 16'($urandom_range(0, 5));
            scenario(int'(vmin) - 5 + $urandom_range(0, int'(vmax) - int'(vmin) + 9), 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule